// File: doc/BRIEF.md
# Scalar Operand Source Resolver

This block turns an 8-bit scalar operand selector into 32 or 64 bits of operand data for a SIMD compute unit, and routes a destination write to the right place. A selector can name a plain scalar register, one of three special registers placed just below the end of the reserved scalar register area, either half of the 64-bit lane execution mask, an inline floating-point constant, or the instruction literal. The block owns the execution mask register and applies the partial-update rules when either half is written.

Reads and the scalar register file write request are combinational. The register file is reached through two address outputs, one per dword, and two read data inputs. A write into the execution mask takes effect at the next rising clock edge. A selector and width pair that is not allowed raises an error output and blocks every write.

Top module: `sop_resolver`

## Requirements
- R1: Selectors 0 to 101 address scalar register (selector + d) for dword d. data_o carries srf_rdata1_i:srf_rdata0_i for a two-dword operand, and srf_rdata0_i with the upper 32 bits zero for a one-dword operand.
- R2: Selector 106 (condition code) maps dword d to register rsv_cnt_i − 2 + d. Selector 103 (scratch base high) maps to rsv_cnt_i − 3 + d. Selector 102 (scratch base low) maps to rsv_cnt_i − 4 and is an error with a two-dword width.
- R3: Reading selector 126 returns the whole 64-bit execution mask for a two-dword width, and mask bits 31:0 for a one-dword width.
- R4: Reading selector 127 returns mask bits 63:32 in the low dword. A two-dword width on selector 127 is an error.
- R5: A one-dword write through selector 126 replaces mask bits 31:0 and keeps bits 63:32. A two-dword write replaces the whole mask. The new mask shows on exec_o after the next rising clock edge.
- R6: A write through selector 127 places wr_data_i[31:0] in mask bits 63:32 and keeps bits 31:0.
- R7: Selectors 240 to 247 give +0.5, −0.5, +1, −1, +2, −2, +4, −4 in that order. The encoding is IEEE single precision for a one-dword width and IEEE double precision for a two-dword width.
- R8: Selector 248 gives 1/(2π): 0x3E22F983 for a one-dword width and 0x3FC45F306DC9C882 for a two-dword width.
- R9: Selector 255 returns lit_i for a one-dword width and is an error for a two-dword width.
- R10: err_o is raised for any selector outside the listed ones, for an illegal width, and for a write to a constant or to the literal. While err_o is high, srf_we_o is 0 and the mask does not change.
- R11: After reset the execution mask is all ones and err_o is low for a legal selector.
- R12: A legal register write raises srf_we_o bit 0, and also bit 1 for a two-dword width. srf_wdata_o carries wr_data_i, with the low dword going to srf_addr0_o and the high dword going to srf_addr1_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 8 | Operand selector code |
| two_dw_i | input | 1 | 1 for a two-dword operand, 0 for one dword |
| lit_i | input | 32 | Instruction literal |
| rsv_cnt_i | input | IDX_W | Count of reserved scalar registers |
| wr_en_i | input | 1 | Write the operand (destination use) |
| wr_data_i | input | 64 | Write data, dword 0 in the low half |
| srf_addr0_o | output | IDX_W | Register file address for dword 0 |
| srf_addr1_o | output | IDX_W | Register file address for dword 1 |
| srf_rdata0_i | input | 32 | Register file read data for dword 0 |
| srf_rdata1_i | input | 32 | Register file read data for dword 1 |
| srf_we_o | output | 2 | Per-dword write enable to the register file |
| srf_wdata_o | output | 64 | Register file write data |
| data_o | output | 64 | Resolved operand data |
| exec_o | output | 64 | Current execution mask |
| err_o | output | 1 | Illegal selector, width or write |

## Verification
The bench uses the defaults: IDX_W = 7, 102 plain scalar registers, and an all-ones mask at reset. It models the register file so that each read returns a pattern built from its own address. Every mapped index can therefore be seen in data_o. With a reserved count of 40 the three back-counted registers land at distinct addresses, 36 to 39. Writes to the mask go through both halves in sequence, so a value left over from an earlier write shows up if one half is overwritten when it should be kept.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned NUM_SGPR = 102;
  localparam logic [7:0] SEL_FS_LO = 8'd102;
  localparam logic [7:0] SEL_FS_HI = 8'd103;
  localparam logic [7:0] SEL_VCC   = 8'd106;
  localparam logic [7:0] SEL_EX_LO = 8'd126;
  localparam logic [7:0] SEL_EX_HI = 8'd127;
  localparam logic [7:0] SEL_C_MIN = 8'd240;
  localparam logic [7:0] SEL_C_INV = 8'd248;
  localparam logic [7:0] SEL_LIT   = 8'd255;

  typedef enum logic [2:0] {
    K_SGPR, K_EXLO, K_EXHI, K_CONST, K_LIT, K_BAD
  } src_kind_e;
endpackage

// File: rtl/sop_index_map.sv
module sop_index_map
  import sop_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic [7:0]       sel_i,
  input  logic [IDX_W-1:0] rsv_cnt_i,
  output src_kind_e        kind_o,
  output logic [IDX_W-1:0] addr0_o,
  output logic [IDX_W-1:0] addr1_o
);
  logic [IDX_W-1:0] base;

  always_comb begin
    base   = '0;
    kind_o = K_BAD;
    if (sel_i < 8'(NUM_SGPR)) begin
      kind_o = K_SGPR;
      base   = IDX_W'(sel_i);
    end else if (sel_i == SEL_VCC) begin
      kind_o = K_SGPR;
      base   = rsv_cnt_i - IDX_W'(2);
    end else if (sel_i == SEL_FS_HI) begin
      kind_o = K_SGPR;
      base   = rsv_cnt_i - IDX_W'(3);
    end else if (sel_i == SEL_FS_LO) begin
      kind_o = K_SGPR;
      base   = rsv_cnt_i - IDX_W'(4);
    end else if (sel_i == SEL_EX_LO) begin
      kind_o = K_EXLO;
    end else if (sel_i == SEL_EX_HI) begin
      kind_o = K_EXHI;
    end else if (sel_i >= SEL_C_MIN && sel_i <= SEL_C_INV) begin
      kind_o = K_CONST;
    end else if (sel_i == SEL_LIT) begin
      kind_o = K_LIT;
    end
  end

  assign addr0_o = base;
  assign addr1_o = base + IDX_W'(1);
endmodule

// File: rtl/sop_const_gen.sv
module sop_const_gen
  import sop_pkg::*;
(
  input  logic [7:0]  sel_i,
  input  logic        two_dw_i,
  output logic [63:0] val_o
);
  localparam logic [31:0] INV2PI_SP = 32'h3E22F983;
  localparam logic [63:0] INV2PI_DP = 64'h3FC45F306DC9C882;

  logic       neg;
  logic [1:0] pow;

  // selector bits 2:1 step the magnitude 0.5,1,2,4; bit 0 is the sign
  assign neg = sel_i[0];
  assign pow = sel_i[2:1];

  always_comb begin
    if (sel_i == SEL_C_INV)
      val_o = two_dw_i ? INV2PI_DP : {32'h0, INV2PI_SP};
    else if (two_dw_i)
      val_o = {neg, 11'd1022 + 11'(pow), 52'h0};
    else
      val_o = {32'h0, neg, 8'd126 + 8'(pow), 23'h0};
  end
endmodule

// File: rtl/sop_exec_mask.sv
module sop_exec_mask #(
  parameter logic [63:0] RST_VAL = '1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  we_i,
  input  logic [63:0] wdata_i,
  output logic [63:0] mask_o
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [31:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= RST_VAL[h*32 +: 32];
      else if (we_i[h]) q <= wdata_i[h*32 +: 32];
    end
    assign mask_o[h*32 +: 32] = q;

    p_half_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i[h] |=> mask_o[h*32 +: 32] == $past(mask_o[h*32 +: 32]));
  end
endmodule

// File: rtl/sop_resolver.sv
module sop_resolver
  import sop_pkg::*;
#(
  parameter int unsigned IDX_W    = 7,
  parameter logic [63:0] EXEC_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       sel_i,
  input  logic             two_dw_i,
  input  logic [31:0]      lit_i,
  input  logic [IDX_W-1:0] rsv_cnt_i,
  input  logic             wr_en_i,
  input  logic [63:0]      wr_data_i,
  output logic [IDX_W-1:0] srf_addr0_o,
  output logic [IDX_W-1:0] srf_addr1_o,
  input  logic [31:0]      srf_rdata0_i,
  input  logic [31:0]      srf_rdata1_i,
  output logic [1:0]       srf_we_o,
  output logic [63:0]      srf_wdata_o,
  output logic [63:0]      data_o,
  output logic [63:0]      exec_o,
  output logic             err_o
);
  src_kind_e   kind;
  logic [63:0] cval;
  logic [63:0] raw;
  logic        width_bad;
  logic        wr_bad;
  logic        wr_ok;
  logic [1:0]  ex_we;
  logic [63:0] ex_wdata;

  sop_index_map #(.IDX_W(IDX_W)) u_map (
    .sel_i     (sel_i),
    .rsv_cnt_i (rsv_cnt_i),
    .kind_o    (kind),
    .addr0_o   (srf_addr0_o),
    .addr1_o   (srf_addr1_o)
  );

  sop_const_gen u_const (
    .sel_i    (sel_i),
    .two_dw_i (two_dw_i),
    .val_o    (cval)
  );

  assign width_bad = two_dw_i &&
    (sel_i == SEL_FS_LO || sel_i == SEL_EX_HI || sel_i == SEL_LIT);
  assign wr_bad    = wr_en_i && (kind == K_CONST || kind == K_LIT);
  assign err_o     = (kind == K_BAD) || width_bad || wr_bad;
  assign wr_ok     = wr_en_i && !err_o;

  always_comb begin
    unique case (kind)
      K_SGPR:  raw = {srf_rdata1_i, srf_rdata0_i};
      K_EXLO:  raw = exec_o;
      K_EXHI:  raw = {32'h0, exec_o[63:32]};
      K_CONST: raw = cval;
      K_LIT:   raw = {32'h0, lit_i};
      default: raw = '0;
    endcase
  end
  assign data_o = two_dw_i ? raw : {32'h0, raw[31:0]};

  assign srf_we_o    = (wr_ok && kind == K_SGPR) ? {two_dw_i, 1'b1} : 2'b00;
  assign srf_wdata_o = wr_data_i;

  assign ex_we[0]  = wr_ok && kind == K_EXLO;
  assign ex_we[1]  = wr_ok && ((kind == K_EXLO && two_dw_i) || kind == K_EXHI);
  assign ex_wdata  = (kind == K_EXHI) ? {wr_data_i[31:0], wr_data_i[31:0]}
                                      : wr_data_i;

  sop_exec_mask #(.RST_VAL(EXEC_RST)) u_exec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ex_we),
    .wdata_i (ex_wdata),
    .mask_o  (exec_o)
  );

  p_err_no_srf_we_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> srf_we_o == 2'b00);
  p_err_mask_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> exec_o == $past(exec_o));
  p_hi_write_keeps_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_EX_HI && !err_o)
      |=> exec_o[31:0] == $past(exec_o[31:0]));
  p_lo_narrow_keeps_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_EX_LO && !two_dw_i)
      |=> exec_o[63:32] == $past(exec_o[63:32]));
  p_hi_wide_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_EX_HI && two_dw_i) |-> err_o);
  p_we_order_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srf_we_o[1] |-> srf_we_o[0]);
endmodule

// File: tb/sim_sop_resolver.sv
module sim_sop_resolver;
  localparam int IDX_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       sel = '0;
  logic             two_dw = 1'b0;
  logic [31:0]      lit = '0;
  logic [IDX_W-1:0] rsv = 7'd40;
  logic             wr_en = 1'b0;
  logic [63:0]      wr_data = '0;
  logic [IDX_W-1:0] a0, a1;
  logic [31:0]      rd0, rd1;
  logic [1:0]       we;
  logic [63:0]      wdata, data, exec_m;
  logic             err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // register file model: each word encodes its own address
  assign rd0 = 32'hA500_0000 | 32'(a0);
  assign rd1 = 32'hA500_0000 | 32'(a1);

  sop_resolver #(.IDX_W(IDX_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .two_dw_i(two_dw), .lit_i(lit),
    .rsv_cnt_i(rsv), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .srf_addr0_o(a0), .srf_addr1_o(a1), .srf_rdata0_i(rd0), .srf_rdata1_i(rd1),
    .srf_we_o(we), .srf_wdata_o(wdata), .data_o(data), .exec_o(exec_m),
    .err_o(err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at falling edge, settle, inputs stay until next drive
  task automatic drive(input logic [7:0] s, input logic w2, input logic we_in,
                       input logic [63:0] wd);
    @(negedge clk);
    sel = s; two_dw = w2; wr_en = we_in; wr_data = wd;
    #2;
  endtask

  task automatic idle();
    drive(8'd0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_reset();
    idle();
    chk("R11 mask after reset", exec_m, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R11 no error", 64'(err), 64'd0);
  endtask

  task automatic t_sgpr();
    drive(8'd5, 1'b0, 1'b0, '0);
    chk("R1 addr0 narrow", 64'(a0), 64'd5);
    chk("R1 data narrow", data, 64'h0000_0000_A500_0005);
    drive(8'd10, 1'b1, 1'b0, '0);
    chk("R1 data wide", data, 64'hA500_000B_A500_000A);
    drive(8'd101, 1'b0, 1'b0, '0);
    chk("R1 last register", data, 64'h0000_0000_A500_0065);
  endtask

  task automatic t_special();
    drive(8'd106, 1'b1, 1'b0, '0);
    chk("R2 vcc addr0", 64'(a0), 64'd38);
    chk("R2 vcc data", data, 64'hA500_0027_A500_0026);
    drive(8'd103, 1'b1, 1'b0, '0);
    chk("R2 fs_hi data", data, 64'hA500_0026_A500_0025);
    drive(8'd102, 1'b0, 1'b0, '0);
    chk("R2 fs_lo addr0", 64'(a0), 64'd36);
    chk("R2 fs_lo err", 64'(err), 64'd0);
    drive(8'd102, 1'b1, 1'b0, '0);
    chk("R2 fs_lo wide err", 64'(err), 64'd1);
  endtask

  task automatic t_exec();
    drive(8'd126, 1'b1, 1'b1, 64'h1234_5678_9ABC_DEF0);
    idle();
    chk("R5 wide write", exec_m, 64'h1234_5678_9ABC_DEF0);
    drive(8'd126, 1'b0, 1'b1, 64'hFFFF_FFFF_1111_2222);
    idle();
    chk("R5 narrow write keeps hi", exec_m, 64'h1234_5678_1111_2222);
    drive(8'd127, 1'b0, 1'b1, 64'h0000_0000_AAAA_BBBB);
    idle();
    chk("R6 hi write keeps lo", exec_m, 64'hAAAA_BBBB_1111_2222);
    drive(8'd126, 1'b1, 1'b0, '0);
    chk("R3 read wide", data, 64'hAAAA_BBBB_1111_2222);
    drive(8'd126, 1'b0, 1'b0, '0);
    chk("R3 read narrow", data, 64'h0000_0000_1111_2222);
    drive(8'd127, 1'b0, 1'b0, '0);
    chk("R4 read hi", data, 64'h0000_0000_AAAA_BBBB);
    drive(8'd127, 1'b1, 1'b1, 64'h5555_5555_5555_5555);
    chk("R4 hi wide err", 64'(err), 64'd1);
    idle();
    chk("R10 mask unchanged", exec_m, 64'hAAAA_BBBB_1111_2222);
  endtask

  task automatic t_const();
    logic [31:0] sp [8];
    logic [63:0] dp [8];
    sp = '{32'h3F00_0000, 32'hBF00_0000, 32'h3F80_0000, 32'hBF80_0000,
           32'h4000_0000, 32'hC000_0000, 32'h4080_0000, 32'hC080_0000};
    dp = '{64'h3FE0_0000_0000_0000, 64'hBFE0_0000_0000_0000,
           64'h3FF0_0000_0000_0000, 64'hBFF0_0000_0000_0000,
           64'h4000_0000_0000_0000, 64'hC000_0000_0000_0000,
           64'h4010_0000_0000_0000, 64'hC010_0000_0000_0000};
    for (int i = 0; i < 8; i++) begin
      drive(8'(240 + i), 1'b0, 1'b0, '0);
      chk("R7 single", data, {32'h0, sp[i]});
      drive(8'(240 + i), 1'b1, 1'b0, '0);
      chk("R7 double", data, dp[i]);
    end
    drive(8'd248, 1'b0, 1'b0, '0);
    chk("R8 single", data, 64'h0000_0000_3E22_F983);
    drive(8'd248, 1'b1, 1'b0, '0);
    chk("R8 double", data, 64'h3FC4_5F30_6DC9_C882);
  endtask

  task automatic t_lit();
    lit = 32'hCAFE_F00D;
    drive(8'd255, 1'b0, 1'b0, '0);
    chk("R9 literal", data, 64'h0000_0000_CAFE_F00D);
    chk("R9 literal no err", 64'(err), 64'd0);
    drive(8'd255, 1'b1, 1'b0, '0);
    chk("R9 literal wide err", 64'(err), 64'd1);
  endtask

  task automatic t_errors();
    drive(8'd242, 1'b0, 1'b1, 64'h1);
    chk("R10 const write err", 64'(err), 64'd1);
    chk("R10 const write no we", 64'(we), 64'd0);
    drive(8'd110, 1'b0, 1'b1, 64'h1);
    chk("R10 unknown sel err", 64'(err), 64'd1);
    chk("R10 unknown sel no we", 64'(we), 64'd0);
    drive(8'd102, 1'b1, 1'b1, 64'h1);
    chk("R10 fs_lo wide no we", 64'(we), 64'd0);
  endtask

  task automatic t_srf_write();
    drive(8'd20, 1'b1, 1'b1, 64'hDEAD_BEEF_0BAD_F00D);
    chk("R12 wide we", 64'(we), 64'd3);
    chk("R12 addr1", 64'(a1), 64'd21);
    chk("R12 wdata", wdata, 64'hDEAD_BEEF_0BAD_F00D);
    drive(8'd106, 1'b0, 1'b1, 64'h7);
    chk("R12 narrow we", 64'(we), 64'd1);
    chk("R12 vcc addr0", 64'(a0), 64'd38);
    drive(8'd126, 1'b0, 1'b1, 64'h0);
    chk("R12 mask write no srf we", 64'(we), 64'd0);
    idle();
  endtask

  initial begin
    #35 rst_n = 1'b1;
    t_reset();
    t_sgpr();
    t_special();
    t_exec();
    t_const();
    t_lit();
    t_errors();
    t_srf_write();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule